// File: doc/BRIEF.md
# Tracking Counter ADC Controller

This block is the digital half of a feedback-type analog-to-digital converter. It holds an N-bit code that drives an external DAC. An external comparator reports whether the analog input lies above the DAC output. The controller moves the code one LSB toward the input on each step. Because the code is never cleared between samples, the loop follows a slowly moving input continuously. At any time the code is the digital value of the input.

The comparator level comes from the analog domain, so it passes through a synchronizer chain before it is used. The controller takes a step only once the comparator has had time to react to the previous step. The step interval is the synchronizer depth plus one clock. With this pacing, a settled loop dithers by exactly one LSB.

The code saturates at both rails instead of wrapping. A locked flag reports that the loop has settled into that one-LSB dither. An enable input freezes the loop.

Top module: `tca_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `dac_code` to 0 and clears `locked`. Both hold these values in the cycle after that edge.
- R2: `cmp_above` = 1 means the input is above the DAC output, and each step then raises the code by one LSB. `cmp_above` = 0 means the input is at or below the DAC output, and each step then lowers the code by one LSB. The code never changes by more than one LSB per clock.
- R3: The code saturates. With `cmp_above` held high the code stops at 2^CODE_W-1 and stays there. With `cmp_above` held low it stops at 0 and stays there. It never wraps from one rail to the other.
- R4: `cmp_above` passes through a SYNC_STAGES-flop synchronizer. While `en` is high, steps occur exactly once every SYNC_STAGES+1 clocks (every 3 clocks by default), so during a ramp 30 clocks move the code by exactly 10.
- R5: While `en` is low, `dac_code` and `locked` hold their values, whatever `cmp_above` does.
- R6: With a constant input whose comparator threshold is T, meaning `cmp_above` = 1 exactly when the code is below T, with 1 <= T <= 2^CODE_W-1, the code settles to alternate between T-1 and T.
- R7: Each step records its direction. `locked` rises after two consecutive steps that each reverse the previous direction. `locked` clears on any step in the same direction as the one before. A loop pinned at a rail therefore never reports lock.
- R8: After a small change of the input, a few LSBs, the code reaches the new T-1/T pair within a few step intervals, without restarting from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Loop enable; low freezes code and lock state |
| cmp_above | input | 1 | Asynchronous comparator level: 1 = input above DAC output |
| dac_code | output | CODE_W | Code driven to the DAC; the conversion result |
| locked | output | 1 | Loop settled into one-LSB dither |

## Verification
The bench builds the block with CODE_W = 6 and the default two-stage synchronizer, so a step occurs every three clocks. At that width a full rail-to-rail run takes under 200 clocks. This brings both saturation rails, settling, re-tracking after a small change and loss of lock within a short run. A behavioural comparator in the bench closes the loop against an integer threshold. Thresholds above the full scale and at zero drive the code into each rail.

// File: rtl/tca_pkg.sv
package tca_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/tca_sync.sv
module tca_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tca_counter.sv
module tca_counter
  import tca_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int GAP    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  dir_e              dir,
  output logic [CODE_W-1:0] code,
  output logic              step
);
  localparam int                PACE_W = $clog2(GAP + 1);
  localparam logic [PACE_W-1:0] PACE_RELOAD = PACE_W'(GAP - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [PACE_W-1:0] pace;
  logic              at_top, at_bot;

  assign at_top = (code == CODE_MAX);
  assign at_bot = (code == '0);
  assign step   = en && (pace == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pace <= '0;
      code <= '0;
    end else if (en) begin
      if (pace == '0) pace <= PACE_RELOAD;
      else            pace <= pace - 1'b1;
      if (step) begin
        if (dir == DIR_UP && !at_top)        code <= code + 1'b1;
        else if (dir == DIR_DOWN && !at_bot) code <= code - 1'b1;
      end
    end
  end

  // R2: at most one LSB of movement per clock
  p_one_lsb_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (code == $past(code)) || (code == $past(code) + 1'b1) ||
             (code == $past(code) - 1'b1));

  // R3: no wrap in either direction
  p_no_wrap_top_r3: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_MAX) |=> (code != '0));
  p_no_wrap_bot_r3: assert property (@(posedge clk) disable iff (rst)
    (code == '0) |=> (code != CODE_MAX));

  // R4: steps are spaced apart to cover the synchronizer latency
  p_step_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);

  // R5: disabled loop does not move
  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(code));
endmodule

// File: rtl/tca_lock.sv
module tca_lock
  import tca_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  dir_e step_dir,
  output logic locked
);
  logic       have_prev;
  dir_e       prev_dir;
  logic [1:0] rev_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_dir  <= DIR_DOWN;
      rev_cnt   <= 2'd0;
    end else if (step) begin
      have_prev <= 1'b1;
      prev_dir  <= step_dir;
      if (have_prev && step_dir != prev_dir) begin
        if (rev_cnt != 2'd2) rev_cnt <= rev_cnt + 2'd1;
      end else begin
        rev_cnt <= 2'd0;
      end
    end
  end

  assign locked = (rev_cnt == 2'd2);

  // R7: lock state only changes on a step
  p_lock_on_step_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(step));
  p_unlock_on_step_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(step));
endmodule

// File: rtl/tca_ctrl.sv
module tca_ctrl
  import tca_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cmp_above,
  output logic [CODE_W-1:0] dac_code,
  output logic              locked
);
  localparam int STEP_GAP = SYNC_STAGES + 1;

  logic cmp_s;
  dir_e dir;
  logic step;

  tca_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_above),
    .q   (cmp_s)
  );

  assign dir = cmp_s ? DIR_UP : DIR_DOWN;

  tca_counter #(.CODE_W(CODE_W), .GAP(STEP_GAP)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .dir  (dir),
    .code (dac_code),
    .step (step)
  );

  tca_lock u_lock (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .step_dir (dir),
    .locked   (locked)
  );

  // R1: reset leaves the code at zero and the flag clear
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (dac_code == '0) && !locked);

  // R5: lock flag frozen while disabled
  p_lock_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(locked));
endmodule

// File: tb/tca_ctrl_tb.sv
module tca_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int MAXC = (1 << W) - 1;

  typedef struct {
    int    lo;
    int    hi;
    int    lk;
    string tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b1;
  logic         cmp_above;
  logic [W-1:0] dac_code;
  logic         locked;
  int           target = 0;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done = 1'b0;
  item_t        q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural comparator: input above DAC output when threshold exceeds code
  assign cmp_above = (target > int'(dac_code));

  tca_ctrl #(.CODE_W(W), .SYNC_STAGES(2)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cmp_above (cmp_above),
    .dac_code  (dac_code),
    .locked    (locked)
  );

  task automatic push(input int lo, input int hi, input int lk, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.lo = lo; it.hi = hi; it.lk = lk; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (int'(dac_code) < it.lo || int'(dac_code) > it.hi ||
            (it.lk >= 0 && int'(locked) != it.lk)) begin
          n_bad++;
          $display("FAIL %s: code=%0d locked=%0d expected code %0d..%0d locked=%0d",
                   it.tag, dac_code, locked, it.lo, it.hi, it.lk);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c0;
    int c1;
    int frz_code;
    int frz_lk;
    cyc(3);
    push(0, 0, 0, "R1 reset state");
    @(negedge clk); rst = 1'b0;

    // ramp rate: one step per three clocks
    target = 40;
    cyc(20); @(negedge clk); c0 = int'(dac_code);
    cyc(30); @(negedge clk); c1 = int'(dac_code);
    push(c0 + 10, c0 + 10, -1, "R4 ramp of 10 per 30 clocks");
    push(c1, 63, -1, "R2 code rising under high comparator");

    // settle at 40
    cyc(200);
    push(39, 40, 1, "R6 R7 settled dither and lock at 40");

    // small change: re-track
    target = 42;
    cyc(24);
    push(41, 42, -1, "R8 re-track to 42");
    cyc(40);
    push(41, 42, 1, "R7 relock at 42");

    // large change: lock lost on consecutive same-direction steps
    target = 60;
    cyc(15);
    push(43, 59, 0, "R7 lock cleared while ramping up");

    // freeze
    @(negedge clk); en = 1'b0;
    frz_code = int'(dac_code); frz_lk = int'(locked);
    target = 10;
    cyc(40);
    push(frz_code, frz_code, frz_lk, "R5 code and lock held while disabled");
    @(negedge clk); en = 1'b1;

    // settle downward at 10
    cyc(250);
    push(9, 10, 1, "R2 R6 settled after downward tracking at 10");

    // upper rail
    target = 100;
    cyc(300);
    push(MAXC, MAXC, 0, "R3 saturated at top, no lock");
    cyc(20);
    push(MAXC, MAXC, 0, "R3 held at top without wrap");

    // lower rail
    target = 0;
    cyc(300);
    push(0, 0, 0, "R3 saturated at zero, no lock");
    cyc(20);
    push(0, 0, 0, "R3 held at zero without wrap");

    // threshold at 1
    target = 1;
    cyc(60);
    push(0, 1, 1, "R6 dither at lowest threshold");

    // mid-run reset
    target = 30;
    cyc(200);
    push(29, 30, 1, "R6 settled at 30");
    @(negedge clk); rst = 1'b1;
    cyc(1);
    push(0, 0, 0, "R1 synchronous reset mid-run");
    @(negedge clk); rst = 1'b0;

    cyc(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule